// File: doc/BRIEF.md
# Page-Mapped Address Translator with Protection

This block is the translation and protection unit for a 32 MB logical address space. That space is backed by up to 128 physical pages. Software sets the page size through a small configuration input. It then programs mappings by issuing writes into a reserved address window. The write carries no data. The write address alone holds the logical page, the physical page, a two-bit protection code and a controller number. Where each of these fields sits depends on the current page size, and the physical page field is bit-permuted in a way that also depends on page size.

The unit stores one entry per physical page. Each entry holds a valid flag, a logical page number and a protection code. For every access it compares the logical page against all entries in parallel. It forms the physical address by placing the matching physical page number above the page offset, then checks the access against the processor privilege mode. One cycle after the request, it returns the result with an abort flag. The abort flag is raised on a miss or on a protection violation.

Top module: `mmu_xlate`

## Requirements
- R1: After reset the result-valid output is low, the page size is 4 KB (code 00), and every entry is invalid, so any access aborts.
- R2: When `cfg_we` is high at a clock edge, the page size is loaded from `cfg_size`: 00 selects 4 KB, 01 selects 8 KB, 10 selects 16 KB, 11 selects 32 KB.
- R3: A table write takes effect only if two conditions hold. First, `tbl_addr[25:23]` must be 111. Second, the controller number must equal the parameter `CTRL_ID`. The controller number is {`tbl_addr[12]`, `tbl_addr[7]`}, with the upper bit forced to 0 at the 4 KB size. Any other table write leaves every mapping unchanged.
- R4: The logical page of a table write is n = 13 - size-code bits wide. Its two most significant bits are `tbl_addr[11]` then `tbl_addr[10]`. Its remaining n-2 bits are `tbl_addr[22]` downward. The access logical page is `acc_addr[24:12+size-code]`.
- R5: The physical page p is unpermuted from the field f = `tbl_addr[6:0]` as follows:
  - 4 KB: p = f.
  - 8 KB: p[5:0] = f[6:1] and p[6] = f[0].
  - 16 KB: p[4:0] = f[6:2] and p[6:5] = f[1:0].
  - 32 KB: p[3:0] = f[6:3], p[4] = f[0], p[5] = f[2] and p[6] = f[1].
- R6: `res_valid` follows `acc_valid` one clock later. On a permitted hit, `res_paddr` equals the physical page shifted left by 12 + size-code, ORed with the page offset of `acc_addr`.
- R7: Writing a physical page replaces that page's previous mapping. The same write invalidates any other entry that holds the same logical page, so the most recent mapping wins.
- R8: In supervisor mode (`acc_mode` 10), every hit may be read and written.
- R9: In OS mode (`acc_mode` 01), a page with protection bit 1 clear is read/write. A page with protection bit 1 set is read-only.
- R10: In user mode (`acc_mode` 00, and also 11), the protection code decides access. Protection 1x makes the page inaccessible. 01 makes it read-only. 00 makes it read/write.
- R11: A miss, or a denied access, sets `res_abort`, and `res_paddr` is zero whenever `res_abort` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load page-size configuration |
| cfg_size | input | 2 | Page-size code |
| tbl_we | input | 1 | Page-table write strobe |
| tbl_addr | input | 26 | Page-table write address (encodes the whole entry) |
| acc_valid | input | 1 | Access request |
| acc_addr | input | 25 | Logical address of the access |
| acc_write | input | 1 | 1 = write access, 0 = read |
| acc_mode | input | 2 | Privilege: 00 user, 01 OS, 10 supervisor, 11 user |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_abort | output | 1 | Access aborted (miss or protection fault) |
| res_paddr | output | 22 | Translated physical address |

## Verification
The checks assume several things about the inputs. A table write and an access in the same cycle are not expected to interact: the access sees the table as it was before that write. The page size is assumed to change only while the table holds no live entries, because stored logical pages are not re-encoded when the size changes. The stimulus therefore never overlaps table writes with accesses, and it resets the unit before each change of page size. Every access is issued for exactly one cycle, at mid-cycle, so that each result lines up with a single request.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

    localparam int PPN_W      = 7;
    localparam int NUM_PAGES  = 1 << PPN_W;
    localparam int BASE_SHIFT = 12;
    localparam int VA_W       = 25;
    localparam int WA_W       = 26;
    localparam int LPN_W      = VA_W - BASE_SHIFT;
    localparam int PA_W       = PPN_W + BASE_SHIFT + 3;

    typedef enum logic [1:0] {
        PG_4K  = 2'b00,
        PG_8K  = 2'b01,
        PG_16K = 2'b10,
        PG_32K = 2'b11
    } pg_size_e;

    typedef enum logic [1:0] {
        MD_USER  = 2'b00,
        MD_OS    = 2'b01,
        MD_SUPER = 2'b10,
        MD_USER2 = 2'b11
    } mode_e;

    // Undo the size-dependent permutation of the physical page field.
    function automatic logic [PPN_W-1:0] ppn_unscramble(pg_size_e sz, logic [PPN_W-1:0] f);
        logic [PPN_W-1:0] p;
        unique case (sz)
            PG_4K:  p = f;
            PG_8K:  p = {f[0], f[6:1]};
            PG_16K: p = {f[1:0], f[6:2]};
            PG_32K: p = {f[1], f[2], f[0], f[6:3]};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/mmu_wr_decode.sv
module mmu_wr_decode
    import mmu_pkg::*;
#(
    parameter logic [1:0] CTRL_ID = 2'd0
) (
    input  logic                tbl_we,
    input  logic [WA_W-1:0]     tbl_addr,
    input  pg_size_e            size,
    output logic                wr_en,
    output logic [PPN_W-1:0]    wr_ppn,
    output logic [LPN_W-1:0]    wr_lpn,
    output logic [1:0]          wr_perm
);
    logic [1:0]       ctrl_num;
    logic [LPN_W-1:0] lpn_raw;

    always_comb begin
        ctrl_num = {(size == PG_4K) ? 1'b0 : tbl_addr[12], tbl_addr[7]};
        wr_en    = tbl_we && (tbl_addr[25:23] == 3'b111) && (ctrl_num == CTRL_ID);
        // Two top bits from 11:10, then 22 downward; the shift drops
        // the low bits that carry no logical page at larger sizes.
        lpn_raw  = {tbl_addr[11:10], tbl_addr[22:12]};
        wr_lpn   = lpn_raw >> size;
        wr_perm  = tbl_addr[9:8];
        wr_ppn   = ppn_unscramble(size, tbl_addr[6:0]);
    end

endmodule

// File: rtl/mmu_page_table.sv
module mmu_page_table
    import mmu_pkg::*;
#(
    parameter int ENTRIES = NUM_PAGES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [PPN_W-1:0]    wr_ppn,
    input  logic [LPN_W-1:0]    wr_lpn,
    input  logic [1:0]          wr_perm,
    input  logic [LPN_W-1:0]    look_lpn,
    output logic [ENTRIES-1:0]  match_vec,
    output logic                hit,
    output logic [PPN_W-1:0]    hit_ppn,
    output logic [1:0]          hit_perm
);
    logic [ENTRIES-1:0] valid_q;
    logic [LPN_W-1:0]   lpn_q  [ENTRIES];
    logic [1:0]         perm_q [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                lpn_q[i]  <= '0;
                perm_q[i] <= '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (PPN_W'(i) == wr_ppn) begin
                    valid_q[i] <= 1'b1;
                    lpn_q[i]   <= wr_lpn;
                    perm_q[i]  <= wr_perm;
                end else if (valid_q[i] && (lpn_q[i] == wr_lpn)) begin
                    valid_q[i] <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        hit_ppn  = '0;
        hit_perm = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            match_vec[i] = valid_q[i] && (lpn_q[i] == look_lpn);
            if (match_vec[i]) begin
                hit_ppn  = hit_ppn | PPN_W'(i);
                hit_perm = hit_perm | perm_q[i];
            end
        end
        hit = |match_vec;
    end

endmodule

// File: rtl/mmu_perm_check.sv
module mmu_perm_check
    import mmu_pkg::*;
(
    input  logic       hit,
    input  logic [1:0] perm,
    input  logic       is_write,
    input  mode_e      mode,
    output logic       deny
);
    always_comb begin
        if (!hit) begin
            deny = 1'b1;
        end else begin
            unique case (mode)
                MD_SUPER: deny = 1'b0;
                MD_OS:    deny = is_write && perm[1];
                default:  deny = perm[1] || (is_write && perm[0]);
            endcase
        end
    end

endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
    import mmu_pkg::*;
#(
    parameter logic [1:0] CTRL_ID = 2'd0,
    parameter int         ENTRIES = NUM_PAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_size,
    input  logic              tbl_we,
    input  logic [25:0]       tbl_addr,
    input  logic              acc_valid,
    input  logic [24:0]       acc_addr,
    input  logic              acc_write,
    input  logic [1:0]        acc_mode,
    output logic              res_valid,
    output logic              res_abort,
    output logic [21:0]       res_paddr
);
    pg_size_e            size_q;
    logic                wr_en;
    logic [PPN_W-1:0]    wr_ppn;
    logic [LPN_W-1:0]    wr_lpn;
    logic [1:0]          wr_perm;
    logic [LPN_W-1:0]    look_lpn;
    logic [ENTRIES-1:0]  match_vec;
    logic                hit;
    logic [PPN_W-1:0]    hit_ppn;
    logic [1:0]          hit_perm;
    logic                deny;
    logic [PA_W-1:0]     off_mask;
    logic [PA_W-1:0]     pa_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      size_q <= PG_4K;
        else if (cfg_we) size_q <= pg_size_e'(cfg_size);
    end

    mmu_wr_decode #(.CTRL_ID(CTRL_ID)) dec_i (
        .tbl_we  (tbl_we),
        .tbl_addr(tbl_addr),
        .size    (size_q),
        .wr_en   (wr_en),
        .wr_ppn  (wr_ppn),
        .wr_lpn  (wr_lpn),
        .wr_perm (wr_perm)
    );

    mmu_page_table #(.ENTRIES(ENTRIES)) tbl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_ppn   (wr_ppn),
        .wr_lpn   (wr_lpn),
        .wr_perm  (wr_perm),
        .look_lpn (look_lpn),
        .match_vec(match_vec),
        .hit      (hit),
        .hit_ppn  (hit_ppn),
        .hit_perm (hit_perm)
    );

    mmu_perm_check chk_perm_i (
        .hit     (hit),
        .perm    (hit_perm),
        .is_write(acc_write),
        .mode    (mode_e'(acc_mode)),
        .deny    (deny)
    );

    always_comb begin
        look_lpn = acc_addr[VA_W-1:BASE_SHIFT] >> size_q;
        off_mask = (PA_W'(1) << (BASE_SHIFT + int'(size_q))) - PA_W'(1);
        pa_next  = (PA_W'(hit_ppn) << (BASE_SHIFT + int'(size_q)))
                 | (acc_addr[PA_W-1:0] & off_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_abort <= 1'b0;
            res_paddr <= '0;
        end else begin
            res_valid <= acc_valid;
            res_abort <= acc_valid && deny;
            res_paddr <= (acc_valid && !deny) ? pa_next : '0;
        end
    end

endmodule

// File: rtl/mmu_xlate_chk.sv
module mmu_xlate_chk #(
    parameter int ENTRIES = 128
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_valid,
    input logic [1:0]         acc_mode,
    input logic               res_valid,
    input logic               res_abort,
    input logic [21:0]        res_paddr,
    input logic [ENTRIES-1:0] match_vec
);
    // R6
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> res_valid);

    // R6
    idle_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !res_valid);

    // R11
    miss_aborts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (match_vec == '0)) |=> res_abort);

    // R11
    abort_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_abort |-> (res_valid && (res_paddr == '0)));

    // R8
    super_never_denied_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (acc_mode == 2'b10) && (match_vec != '0)) |=> !res_abort);

    // R7
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

endmodule

bind mmu_xlate mmu_xlate_chk #(.ENTRIES(ENTRIES)) prop_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_valid(acc_valid),
    .acc_mode (acc_mode),
    .res_valid(res_valid),
    .res_abort(res_abort),
    .res_paddr(res_paddr),
    .match_vec(match_vec)
);

// File: tb/mmu_xlate_tb_top.sv
module mmu_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_size = 2'b00;
    logic        tbl_we = 1'b0;
    logic [25:0] tbl_addr = '0;
    logic        acc_valid = 1'b0;
    logic [24:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic [1:0]  acc_mode = 2'b00;
    logic        res_valid;
    logic        res_abort;
    logic [21:0] res_paddr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mmu_xlate dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_size (cfg_size),
        .tbl_we   (tbl_we),
        .tbl_addr (tbl_addr),
        .acc_valid(acc_valid),
        .acc_addr (acc_addr),
        .acc_write(acc_write),
        .acc_mode (acc_mode),
        .res_valid(res_valid),
        .res_abort(res_abort),
        .res_paddr(res_paddr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Build a table-write address for size code sz.
    function automatic logic [25:0] enc_waddr(input int sz, input logic [12:0] lpn,
                                              input logic [6:0] p, input logic [1:0] perm,
                                              input logic [1:0] m);
        logic [25:0] a;
        logic [6:0]  f;
        int n;
        n = 13 - sz;
        a = '0;
        a[25:23] = 3'b111;
        a[11] = lpn[n-1];
        a[10] = lpn[n-2];
        for (int i = 0; i < n - 2; i++) a[22-i] = lpn[n-3-i];
        a[9:8] = perm;
        a[7] = m[0];
        if (sz != 0) a[12] = m[1];
        case (sz)
            0: f = p;
            1: f = {p[5:0], p[6]};
            2: f = {p[4:0], p[6:5]};
            default: f = {p[3:0], p[5], p[6], p[4]};
        endcase
        a[6:0] = f;
        return a;
    endfunction

    function automatic logic [24:0] va_of(input int sz, input logic [12:0] lpn, input int off);
        return 25'((32'(lpn) << (12 + sz)) | 32'(off));
    endfunction

    function automatic logic [21:0] pa_of(input int sz, input logic [6:0] p, input int off);
        return 22'((32'(p) << (12 + sz)) | 32'(off));
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_size(input int sz);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_size = 2'(sz);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic raw_write(input logic [25:0] a);
        @(negedge clk);
        tbl_we = 1'b1;
        tbl_addr = a;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic map(input int sz, input logic [12:0] lpn, input logic [6:0] p,
                       input logic [1:0] perm);
        raw_write(enc_waddr(sz, lpn, p, perm, 2'b00));
    endtask

    task automatic access(input logic [24:0] va, input bit wr, input logic [1:0] md,
                          input bit exp_abort, input logic [21:0] exp_pa, input string req);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_addr = va;
        acc_write = wr;
        acc_mode = md;
        @(negedge clk);
        acc_valid = 1'b0;
        chk(res_valid === 1'b1, req, "res_valid", 32'(res_valid), 32'd1);
        chk(res_abort === exp_abort, req, "res_abort", 32'(res_abort), 32'(exp_abort));
        chk(res_paddr === (exp_abort ? 22'd0 : exp_pa), req, "res_paddr",
            32'(res_paddr), 32'(exp_abort ? 22'd0 : exp_pa));
    endtask

    task automatic t_reset();
        do_reset();
        chk(res_valid === 1'b0, "R1", "res_valid after reset", 32'(res_valid), 32'd0);
        access(va_of(0, 13'h000, 0), 1'b0, 2'b10, 1'b1, '0, "R1");
        access(va_of(0, 13'h1FFF, 12'hFFF), 1'b0, 2'b10, 1'b1, '0, "R11");
    endtask

    task automatic t_4k();
        do_reset();
        map(0, 13'h155, 7'h2A, 2'b00);
        access(va_of(0, 13'h155, 12'hABC), 1'b0, 2'b00, 1'b0, pa_of(0, 7'h2A, 12'hABC), "R4 R5 R6");
        access(va_of(0, 13'h155, 12'h001), 1'b1, 2'b00, 1'b0, pa_of(0, 7'h2A, 12'h001), "R10");
        access(va_of(0, 13'h154, 12'h001), 1'b0, 2'b10, 1'b1, '0, "R11");
    endtask

    task automatic t_size(input int sz, input logic [12:0] lpn, input logic [6:0] p, input int off);
        do_reset();
        set_size(sz);
        map(sz, lpn, p, 2'b00);
        access(va_of(sz, lpn, off), 1'b0, 2'b00, 1'b0, pa_of(sz, p, off), "R2 R5");
        access(va_of(sz, lpn ^ 13'h1, off), 1'b0, 2'b00, 1'b1, '0, "R4");
    endtask

    task automatic t_perm();
        do_reset();
        map(0, 13'h010, 7'h10, 2'b10);
        map(0, 13'h011, 7'h11, 2'b01);
        map(0, 13'h012, 7'h12, 2'b11);
        map(0, 13'h013, 7'h13, 2'b00);
        // R9 OS mode
        access(va_of(0, 13'h010, 5), 1'b0, 2'b01, 1'b0, pa_of(0, 7'h10, 5), "R9");
        access(va_of(0, 13'h010, 5), 1'b1, 2'b01, 1'b1, '0, "R9");
        access(va_of(0, 13'h011, 6), 1'b1, 2'b01, 1'b0, pa_of(0, 7'h11, 6), "R9");
        access(va_of(0, 13'h013, 7), 1'b1, 2'b01, 1'b0, pa_of(0, 7'h13, 7), "R9");
        // R10 user mode
        access(va_of(0, 13'h010, 5), 1'b0, 2'b00, 1'b1, '0, "R10");
        access(va_of(0, 13'h011, 6), 1'b0, 2'b00, 1'b0, pa_of(0, 7'h11, 6), "R10");
        access(va_of(0, 13'h011, 6), 1'b1, 2'b00, 1'b1, '0, "R10");
        access(va_of(0, 13'h012, 8), 1'b0, 2'b00, 1'b1, '0, "R10");
        access(va_of(0, 13'h013, 7), 1'b1, 2'b00, 1'b0, pa_of(0, 7'h13, 7), "R10");
        access(va_of(0, 13'h010, 5), 1'b0, 2'b11, 1'b1, '0, "R10");
        // R8 supervisor
        access(va_of(0, 13'h012, 8), 1'b1, 2'b10, 1'b0, pa_of(0, 7'h12, 8), "R8");
        access(va_of(0, 13'h010, 9), 1'b1, 2'b10, 1'b0, pa_of(0, 7'h10, 9), "R8");
    endtask

    task automatic t_last_wins();
        do_reset();
        map(0, 13'h077, 7'h05, 2'b00);
        map(0, 13'h077, 7'h09, 2'b00);
        access(va_of(0, 13'h077, 12'h123), 1'b0, 2'b10, 1'b0, pa_of(0, 7'h09, 12'h123), "R7");
        map(0, 13'h078, 7'h09, 2'b00);
        access(va_of(0, 13'h077, 12'h123), 1'b0, 2'b10, 1'b1, '0, "R7");
        access(va_of(0, 13'h078, 12'h010), 1'b0, 2'b10, 1'b0, pa_of(0, 7'h09, 12'h010), "R7");
    endtask

    task automatic t_ignore();
        logic [25:0] a;
        do_reset();
        set_size(1);
        a = enc_waddr(1, 13'h0321, 7'h22, 2'b00, 2'b00);
        a[25:23] = 3'b110;
        raw_write(a);
        access(va_of(1, 13'h0321, 4), 1'b0, 2'b10, 1'b1, '0, "R3");
        raw_write(enc_waddr(1, 13'h0321, 7'h22, 2'b00, 2'b01));
        access(va_of(1, 13'h0321, 4), 1'b0, 2'b10, 1'b1, '0, "R3");
        raw_write(enc_waddr(1, 13'h0321, 7'h22, 2'b00, 2'b10));
        access(va_of(1, 13'h0321, 4), 1'b0, 2'b10, 1'b1, '0, "R3");
        raw_write(enc_waddr(1, 13'h0321, 7'h22, 2'b00, 2'b00));
        access(va_of(1, 13'h0321, 4), 1'b0, 2'b10, 1'b0, pa_of(1, 7'h22, 4), "R3");
    endtask

    initial begin
        t_reset();
        t_4k();
        t_size(1, 13'h0A5C, 7'h41, 32'h1F0F);
        t_size(2, 13'h05A3, 7'h63, 32'h3001);
        t_size(3, 13'h02C7, 7'h35, 32'h7FFF);
        t_perm();
        t_last_wins();
        t_ignore();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule